// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits at the host side of a parallel NOR-style flash front end. It sees one write strobe per host bus write. Each write carries an address and a command or data byte. The block decodes single-cycle commands and two-cycle setup/confirm sequences. It chooses what a host read returns: the memory array, the identifier bytes or the status byte. It also issues one-cycle start, suspend and resume requests to a simplified write engine.

The write engine reports only a busy level. While that level is high, every read returns the status byte. The status byte holds the ready flag, the suspend flags and the error flags.

The lowest region of the address space is a boot region. An erase or word write aimed at it is carried out only if the write-protect input is high or the reset pin reports its high-voltage level. Otherwise the block refuses the operation and sets a sticky protection error flag.

Top module: `fcd_top`

## Requirements
- R1: After reset, reads return `arrayData`, `statusOut` is 8'h80 and no engine request is asserted.
- R2: Writing FFh selects array reads, 90h selects identifier reads and 70h selects status reads. In identifier mode, `rdAddr[0]`=0 returns `MFR_CODE` and `rdAddr[0]`=1 returns `DEV_CODE`.
- R3: Writing 50h clears the erase-error (bit 5), write-error (bit 4) and protection-error (bit 1) status flags, and leaves the read mode unchanged.
- R4: A 20h write followed by a D0h write at a non-boot address pulses `engStartErase` for one cycle, in the cycle after the confirm write. `engAddr` then holds the confirm address, and reads switch to status.
- R5: A 40h or 10h write followed by any byte pulses `engStartWrite` for one cycle after the second write. `engAddr` and `engData` then hold that write's address and byte.
- R6: If 20h is followed by a byte other than D0h, status bits 5 and 4 are set, no erase starts, and reads switch to status.
- R7: Boot addresses are those with `wrAddr[15:12]`==0. An erase confirm or write data at a boot address with `wpHigh`=0 and `rpHv`=0 starts nothing and sets status bit 1. If either input is 1, the operation starts.
- R8: B0h while the engine is busy and not suspended pulses `engSuspendReq` and sets status bit 6 (erase) or bit 2 (word write). D0h while suspended pulses `engResumeReq` and clears both suspend flags. B0h while the engine is idle does nothing.
- R9: A command byte outside the defined set changes neither the read mode nor any request.
- R10: Status bit 7 is 1 when `engBusy` is low and 0 when it is high. While `engBusy` is high, reads return the status byte whatever the read mode.
- R11: A 20h, 40h or 10h write while `engBusy` is high is ignored, so the following byte is decoded as a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle combined host write strobe |
| wrAddr | input | 16 | Write address |
| wrData | input | 8 | Command or data byte |
| rdAddr | input | 16 | Read address |
| rdData | output | 8 | Read data for the current read mode |
| arrayData | input | 8 | Byte from the memory array at `rdAddr` |
| wpHigh | input | 1 | Write-protect input high (boot region unlocked) |
| rpHv | input | 1 | Reset pin at high voltage (boot region unlocked) |
| engBusy | input | 1 | Write engine busy |
| engStartErase | output | 1 | Start block erase, one-cycle pulse |
| engStartWrite | output | 1 | Start word write, one-cycle pulse |
| engSuspendReq | output | 1 | Suspend request, one-cycle pulse |
| engResumeReq | output | 1 | Resume request, one-cycle pulse |
| engAddr | output | 16 | Target address for the engine |
| engData | output | 8 | Data byte for a word write |
| statusOut | output | 8 | Status byte |

## Verification
The assertions check several rules on every cycle:
- the two start pulses never coincide;
- no start ever reaches a boot address while both unlock inputs were low;
- a resume only follows a recorded suspend, and the two suspend flags are never both set;
- a clear-status strobe leaves all error flags at zero;
- a confirm mismatch always ends in status mode;
- a setup byte arriving while busy leaves the sequencer idle.

Only the bench scenarios can show the other behaviours. These are the exact addresses and data handed to the engine, the identifier and status bytes seen on reads, and which suspend flag a suspend sets. They also include the fact that reserved bytes and idle-time suspends leave everything unchanged.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} readMode_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ERASE, SEQ_WRITE} seqState_t;

  typedef struct packed {
    logic startErase;
    logic startWrite;
    logic suspend;
    logic resume;
    logic seqErr;
    logic protErr;
    logic clrErr;
  } fcdStrobe_t;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_IDENT  = 8'h90;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_WRITE_SETA  = 8'h40;
  localparam logic [7:0] CMD_WRITE_SETB  = 8'h10;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;

  localparam int ST_READY     = 7;
  localparam int ST_ERASE_SUS = 6;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_WRITE_ERR = 4;
  localparam int ST_WRITE_SUS = 2;
  localparam int ST_PROT_ERR  = 1;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  input  logic       engBusy,
  input  logic       suspActive,
  input  logic       bootHit,
  input  logic       protAllow,
  output fcdStrobe_t strobe,
  output readMode_t  readMode
);

  seqState_t state, nextState;
  readMode_t nextMode;
  logic      refuse;

  assign refuse = bootHit && !protAllow;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextMode  = readMode;
    if (wrStb) begin
      unique case (state)
        SEQ_IDLE: begin
          unique case (wrData)
            CMD_READ_ARRAY:  nextMode = RM_ARRAY;
            CMD_READ_IDENT:  nextMode = RM_IDENT;
            CMD_READ_STATUS: nextMode = RM_STATUS;
            CMD_CLR_STATUS:  strobe.clrErr = 1'b1;
            CMD_ERASE_SETUP: begin
              if (!engBusy) begin
                nextState = SEQ_ERASE;
                nextMode  = RM_STATUS;
              end
            end
            CMD_WRITE_SETA, CMD_WRITE_SETB: begin
              if (!engBusy) begin
                nextState = SEQ_WRITE;
                nextMode  = RM_STATUS;
              end
            end
            CMD_SUSPEND: begin
              if (engBusy && !suspActive) begin
                strobe.suspend = 1'b1;
                nextMode       = RM_STATUS;
              end
            end
            CMD_CONFIRM: begin
              if (suspActive) begin
                strobe.resume = 1'b1;
                nextMode      = RM_STATUS;
              end
            end
            default: ;
          endcase
        end
        SEQ_ERASE: begin
          nextState = SEQ_IDLE;
          nextMode  = RM_STATUS;
          if (wrData == CMD_CONFIRM) begin
            if (refuse) strobe.protErr = 1'b1;
            else        strobe.startErase = 1'b1;
          end else begin
            strobe.seqErr = 1'b1;
          end
        end
        SEQ_WRITE: begin
          nextState = SEQ_IDLE;
          nextMode  = RM_STATUS;
          if (refuse) strobe.protErr = 1'b1;
          else        strobe.startWrite = 1'b1;
        end
        default: nextState = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      readMode <= RM_ARRAY;
    end else begin
      state    <= nextState;
      readMode <= nextMode;
    end
  end

  AST_SEQ_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_ERASE && wrStb && wrData != CMD_CONFIRM) |=> (readMode == RM_STATUS && state == SEQ_IDLE)); // R6

  AST_SETUP_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && wrStb && engBusy &&
     (wrData == CMD_ERASE_SETUP || wrData == CMD_WRITE_SETA || wrData == CMD_WRITE_SETB))
    |=> state == SEQ_IDLE); // R11

endmodule

// File: rtl/fcd_dpath.sv
module fcd_dpath
  import fcd_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         BOOT_AW  = 12,
  parameter logic [7:0] MFR_CODE = 8'h5A,
  parameter logic [7:0] DEV_CODE = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcdStrobe_t        strobe,
  input  readMode_t         readMode,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        arrayData,
  input  logic              wpHigh,
  input  logic              rpHv,
  input  logic              engBusy,
  output logic              bootHit,
  output logic              protAllow,
  output logic              suspActive,
  output logic              engStartErase,
  output logic              engStartWrite,
  output logic              engSuspendReq,
  output logic              engResumeReq,
  output logic [ADDR_W-1:0] engAddr,
  output logic [7:0]        engData,
  output logic [7:0]        rdData,
  output logic [7:0]        statusWord
);

  localparam int TAG_W = ADDR_W - BOOT_AW;

  logic eraseSus, writeSus, eraseErr, writeErr, protErr, opIsErase;
  logic engBootHit;

  assign bootHit    = (wrAddr[ADDR_W-1 -: TAG_W] == '0);
  assign engBootHit = (engAddr[ADDR_W-1 -: TAG_W] == '0);
  assign protAllow  = wpHigh || rpHv;
  assign suspActive = eraseSus || writeSus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engStartErase <= 1'b0;
      engStartWrite <= 1'b0;
      engSuspendReq <= 1'b0;
      engResumeReq  <= 1'b0;
      engAddr       <= '0;
      engData       <= '0;
      opIsErase     <= 1'b0;
    end else begin
      engStartErase <= strobe.startErase;
      engStartWrite <= strobe.startWrite;
      engSuspendReq <= strobe.suspend;
      engResumeReq  <= strobe.resume;
      if (strobe.startErase || strobe.startWrite) begin
        engAddr   <= wrAddr;
        engData   <= wrData;
        opIsErase <= strobe.startErase;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseSus <= 1'b0;
      writeSus <= 1'b0;
      eraseErr <= 1'b0;
      writeErr <= 1'b0;
      protErr  <= 1'b0;
    end else begin
      if (strobe.suspend) begin
        if (opIsErase) eraseSus <= 1'b1;
        else           writeSus <= 1'b1;
      end else if (strobe.resume) begin
        eraseSus <= 1'b0;
        writeSus <= 1'b0;
      end
      if (strobe.clrErr) begin
        eraseErr <= 1'b0;
        writeErr <= 1'b0;
        protErr  <= 1'b0;
      end else begin
        if (strobe.seqErr) begin
          eraseErr <= 1'b1;
          writeErr <= 1'b1;
        end
        if (strobe.protErr) protErr <= 1'b1;
      end
    end
  end

  always_comb begin
    statusWord               = '0;
    statusWord[ST_READY]     = !engBusy;
    statusWord[ST_ERASE_SUS] = eraseSus;
    statusWord[ST_ERASE_ERR] = eraseErr;
    statusWord[ST_WRITE_ERR] = writeErr;
    statusWord[ST_WRITE_SUS] = writeSus;
    statusWord[ST_PROT_ERR]  = protErr;
  end

  always_comb begin
    if (engBusy || readMode == RM_STATUS) rdData = statusWord;
    else if (readMode == RM_IDENT)        rdData = rdAddr[0] ? DEV_CODE : MFR_CODE;
    else                                  rdData = arrayData;
  end

  AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(engStartErase && engStartWrite)); // R4

  AST_BOOT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (engStartErase || engStartWrite) |-> (!engBootHit || $past(protAllow))); // R7

  AST_RESUME_AFTER_SUSPEND: assert property (@(posedge clk) disable iff (!rstN)
    engResumeReq |-> $past(suspActive)); // R8

  AST_SUSPEND_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseSus && writeSus)); // R8

  AST_CLEAR_ERRORS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clrErr) |-> (!eraseErr && !writeErr && !protErr)); // R3

endmodule

// File: rtl/fcd_top.sv
module fcd_top
  import fcd_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         BOOT_AW  = 12,
  parameter logic [7:0] MFR_CODE = 8'h5A,
  parameter logic [7:0] DEV_CODE = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic [7:0]        arrayData,
  input  logic              wpHigh,
  input  logic              rpHv,
  input  logic              engBusy,
  output logic              engStartErase,
  output logic              engStartWrite,
  output logic              engSuspendReq,
  output logic              engResumeReq,
  output logic [ADDR_W-1:0] engAddr,
  output logic [7:0]        engData,
  output logic [7:0]        statusOut
);

  fcdStrobe_t strobe;
  readMode_t  readMode;
  logic       bootHit, protAllow, suspActive;

  fcd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrStb      (wrStb),
    .wrData     (wrData),
    .engBusy    (engBusy),
    .suspActive (suspActive),
    .bootHit    (bootHit),
    .protAllow  (protAllow),
    .strobe     (strobe),
    .readMode   (readMode)
  );

  fcd_dpath #(
    .ADDR_W   (ADDR_W),
    .BOOT_AW  (BOOT_AW),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .readMode      (readMode),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .rdAddr        (rdAddr),
    .arrayData     (arrayData),
    .wpHigh        (wpHigh),
    .rpHv          (rpHv),
    .engBusy       (engBusy),
    .bootHit       (bootHit),
    .protAllow     (protAllow),
    .suspActive    (suspActive),
    .engStartErase (engStartErase),
    .engStartWrite (engStartWrite),
    .engSuspendReq (engSuspendReq),
    .engResumeReq  (engResumeReq),
    .engAddr       (engAddr),
    .engData       (engData),
    .rdData        (rdData),
    .statusWord    (statusOut)
  );

endmodule

// File: tb/fcd_top_tb.sv
module fcd_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [15:0] rdAddr = '0;
  logic [7:0]  rdData;
  logic [7:0]  arrayData = 8'hA5;
  logic        wpHigh = 1'b0;
  logic        rpHv = 1'b0;
  logic        engBusy = 1'b0;
  logic        engStartErase, engStartWrite, engSuspendReq, engResumeReq;
  logic [15:0] engAddr;
  logic [7:0]  engData;
  logic [7:0]  statusOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;   // 0 erase, 1 write, 2 suspend, 3 resume
    logic [15:0] addr;
    logic [7:0]  data;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  fcd_top u_dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .arrayData(arrayData),
    .wpHigh(wpHigh), .rpHv(rpHv), .engBusy(engBusy),
    .engStartErase(engStartErase), .engStartWrite(engStartWrite),
    .engSuspendReq(engSuspendReq), .engResumeReq(engResumeReq),
    .engAddr(engAddr), .engData(engData), .statusOut(statusOut)
  );

  // monitor: pops one expectation per observed engine request
  always @(negedge clk) begin
    if (rstN && (engStartErase || engStartWrite || engSuspendReq || engResumeReq)) begin
      int kind;
      kind = engStartErase ? 0 : engStartWrite ? 1 : engSuspendReq ? 2 : 3;
      vectors++;
      if ($countones({engStartErase, engStartWrite, engSuspendReq, engResumeReq}) != 1) begin
        miscompares++;
        $display("FAIL R4: several requests at once, got %b expected one",
                 {engStartErase, engStartWrite, engSuspendReq, engResumeReq});
      end else if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R9: unexpected request kind %0d, got request expected none", kind);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.kind != kind ||
            (kind <= 1 && engAddr != e.addr) ||
            (kind == 1 && engData != e.data)) begin
          miscompares++;
          $display("FAIL %s: got kind %0d addr %h data %h, expected kind %0d addr %h data %h",
                   e.tag, kind, engAddr, engData, e.kind, e.addr, e.data);
        end
      end
    end
  end

  task automatic expect_req(input int kind, input logic [15:0] a, input logic [7:0] d, input string tag);
    expItem_t e;
    e.kind = kind; e.addr = a; e.data = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic writeCmd(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrStb = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic checkRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rdAddr = a;
    #2;
    vectors++;
    if (rdData !== exp) begin
      miscompares++;
      $display("FAIL %s: rdData got %h expected %h", tag, rdData, exp);
    end
  endtask

  task automatic checkStatus(input logic [7:0] exp, input string tag);
    @(negedge clk);
    vectors++;
    if (statusOut !== exp) begin
      miscompares++;
      $display("FAIL %s: statusOut got %h expected %h", tag, statusOut, exp);
    end
  endtask

  task automatic checkQueueEmpty(input string tag);
    repeat (3) @(negedge clk);
    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL %s: %0d requests missing, expected 0", tag, expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkRead(16'h1234, 8'hA5, "R1");
    checkStatus(8'h80, "R1");

    // R2 read modes
    writeCmd(16'h0000, 8'h90);
    checkRead(16'h0000, 8'h5A, "R2");
    checkRead(16'h0001, 8'h3C, "R2");
    writeCmd(16'h0000, 8'h70);
    checkRead(16'h0100, 8'h80, "R2");
    writeCmd(16'h0000, 8'hFF);
    checkRead(16'h0100, 8'hA5, "R2");

    // R9 reserved codes
    writeCmd(16'h2000, 8'h33);
    writeCmd(16'h2000, 8'h00);
    checkRead(16'h0100, 8'hA5, "R9");
    checkQueueEmpty("R9");

    // R4 block erase
    expect_req(0, 16'h5123, 8'h00, "R4");
    writeCmd(16'h5000, 8'h20);
    writeCmd(16'h5123, 8'hD0);
    checkRead(16'h0000, 8'h80, "R4");
    checkQueueEmpty("R4");

    // R10 busy
    engBusy = 1'b1;
    checkRead(16'h0000, 8'h00, "R10");
    checkStatus(8'h00, "R10");

    // R8 erase suspend/resume
    expect_req(2, 16'h0, 8'h0, "R8");
    writeCmd(16'h0000, 8'hB0);
    engBusy = 1'b0;
    checkStatus(8'hC0, "R8");
    expect_req(3, 16'h0, 8'h0, "R8");
    writeCmd(16'h0000, 8'hD0);
    checkStatus(8'h80, "R8");
    checkQueueEmpty("R8");

    // R11 setup ignored while busy; R10 array mode still returns status while busy
    writeCmd(16'h0000, 8'hFF);
    engBusy = 1'b1;
    checkRead(16'h0000, 8'h00, "R10");
    writeCmd(16'h6000, 8'h40);
    writeCmd(16'h6000, 8'hAA);
    engBusy = 1'b0;
    checkRead(16'h0000, 8'hA5, "R11");
    checkQueueEmpty("R11");

    // R5 word write, both setup codes
    expect_req(1, 16'h6002, 8'h77, "R5");
    writeCmd(16'h6000, 8'h40);
    writeCmd(16'h6002, 8'h77);
    expect_req(1, 16'h7000, 8'h11, "R5");
    writeCmd(16'h7000, 8'h10);
    writeCmd(16'h7000, 8'h11);
    checkQueueEmpty("R5");

    // R6 sequence error
    writeCmd(16'h5000, 8'h20);
    writeCmd(16'h5000, 8'hFF);
    checkRead(16'h0000, 8'hB0, "R6");
    checkQueueEmpty("R6");

    // R3 clear status keeps status mode
    writeCmd(16'h0000, 8'h50);
    checkRead(16'h0000, 8'h80, "R3");

    // R7 boot protection
    writeCmd(16'h0100, 8'h20);
    writeCmd(16'h0100, 8'hD0);
    checkStatus(8'h82, "R7");
    writeCmd(16'h0100, 8'h40);
    writeCmd(16'h0010, 8'h99);
    checkStatus(8'h82, "R7");
    checkQueueEmpty("R7");
    writeCmd(16'h0000, 8'h50);
    checkStatus(8'h80, "R3");
    wpHigh = 1'b1;
    expect_req(1, 16'h0010, 8'h99, "R7");
    writeCmd(16'h0010, 8'h40);
    writeCmd(16'h0010, 8'h99);
    wpHigh = 1'b0; rpHv = 1'b1;
    expect_req(0, 16'h0200, 8'h00, "R7");
    writeCmd(16'h0200, 8'h20);
    writeCmd(16'h0200, 8'hD0);
    rpHv = 1'b0;
    checkStatus(8'h80, "R7");
    checkQueueEmpty("R7");

    // R8 suspend while idle ignored
    writeCmd(16'h0000, 8'hFF);
    writeCmd(16'h0000, 8'hB0);
    checkRead(16'h0000, 8'hA5, "R8");
    checkQueueEmpty("R8");

    // R8 word write suspend
    expect_req(1, 16'h8000, 8'h42, "R8");
    writeCmd(16'h8000, 8'h40);
    writeCmd(16'h8000, 8'h42);
    engBusy = 1'b1;
    expect_req(2, 16'h0, 8'h0, "R8");
    writeCmd(16'h0000, 8'hB0);
    engBusy = 1'b0;
    checkStatus(8'h84, "R8");
    expect_req(3, 16'h0, 8'h0, "R8");
    writeCmd(16'h0000, 8'hD0);
    checkStatus(8'h80, "R8");
    checkQueueEmpty("R8");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule